// File: doc/BRIEF.md
# Read-Response Serializer for a Replay-Protected Counter Flash

This block produces the serial answer to the response-read opcode (default 96h) on a single-data-line SPI port, where commands arrive on the input line and data leaves on the output line. Once the opcode has been shifted in, the host gives eight dummy clocks. The block then drives the extended status byte, followed by a 384-bit response buffer. That buffer holds a 96-bit tag, 32-bit counter data and a 256-bit signature. The command controller elsewhere in the device fills the buffer after a request-counter command succeeds. The block does not generate the signature.

The block runs on one system clock and samples the SPI clock, chip select and input line as ordinary synchronous inputs. The output bit changes only on a detected falling SPI clock edge, so it is stable when the host samples it on the rising edge. The host may release chip select at any bit, for example after reading only the status byte to poll the busy flag. It may also keep clocking past the payload, in which case the block drives zeros.

Top module: `op2_resp_ser`

## Requirements
- R1: `spi_miso` is low while `spi_csn` is high, and it stays low during the 8 opcode bits and the 8 dummy clocks of a selection.
- R2: The opcode is sampled from `spi_mosi` on rising `spi_sck` edges, most significant bit first. If it equals 96h, the first falling edge after the 8th dummy rising edge drives status bit 7. `spi_miso` changes only on falling `spi_sck` edges or when the selection ends.
- R3: The response is sent in this order: status[7:0], tag[95:0], counter[31:0], signature[255:0]. Each field is sent most significant bit first, for 392 bits in total.
- R4: A one-cycle `ld_i` pulse stores the tag at buffer bits 383:288, the counter at 287:256 and the signature at 255:0. The buffer holds its contents until the next pulse, and reset clears it to zero.
- R5: The status byte is taken from `stat_i` at the falling edge that drives its first bit. Bit 0 is the busy flag, so a host can poll by reading only the status byte.
- R6: Releasing `spi_csn` ends the response at any bit. The next selection starts again from the opcode phase and sends the frame from status bit 7.
- R7: If a selection carries any opcode other than 96h, `spi_miso` stays low for that whole selection.
- R8: After the 392nd response bit, every further clock drives 0.
- R9: A load during a response in progress does not change that response. The next response carries the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-device data line |
| spi_miso | output | 1 | Device-to-host data line, registered |
| stat_i | input | 8 | Extended status from the command controller; bit 0 is busy |
| ld_i | input | 1 | Load strobe for the response buffer |
| ld_tag_i | input | 96 | Tag to be stored |
| ld_cnt_i | input | 32 | Counter value to be stored |
| ld_sig_i | input | 256 | Signature to be stored |

## Verification
The bench builds the block with its default parameters: an 8-bit opcode of 96h, 8 dummy clocks and field widths of 96, 32 and 256 bits. These values give the full 392-bit frame and the 16-clock preamble. With them, reads of up to 400 data bits reach the overrun zeros past the signature, and aborts at status, tag and counter bit positions can be placed at exact frame offsets. Tag, counter and signature values are random. Directed selections cover the busy poll, a wrong opcode, a reset-cleared buffer and a load in the middle of a response.

// File: rtl/op2_ser_pkg.sv
package op2_ser_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_DUMMY,
    PH_ARMED,
    PH_DATA,
    PH_REJECT
  } op2_phase_e;
endpackage

// File: rtl/op2_sck_edge.sv
module op2_sck_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  assign rise_o = sck & ~sck_q;
  assign fall_o = ~sck & sck_q;
endmodule

// File: rtl/op2_phase_ctl.sv
module op2_phase_ctl
  import op2_ser_pkg::*;
#(
  parameter int              OP_W       = 8,
  parameter int              DUMMY_CLKS = 8,
  parameter logic [OP_W-1:0] OPCODE     = 8'h96
) (
  input  logic clk,
  input  logic rst,
  input  logic csn,
  input  logic mosi,
  input  logic rise,
  input  logic fall,
  output logic load_o,
  output logic shift_o
);
  localparam int CNT_MAX = (OP_W > DUMMY_CLKS) ? OP_W : DUMMY_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  op2_phase_e      ph;
  logic [CNT_W-1:0] cnt;
  logic [OP_W-1:0]  cmd_sr;
  logic [OP_W-1:0]  cmd_next;

  assign cmd_next = {cmd_sr[OP_W-2:0], mosi};

  always_ff @(posedge clk) begin
    if (rst || csn) begin
      ph     <= PH_CMD;
      cnt    <= '0;
      cmd_sr <= '0;
    end else begin
      case (ph)
        PH_CMD: if (rise) begin
          cmd_sr <= cmd_next;
          if (cnt == CNT_W'(OP_W - 1)) begin
            cnt <= '0;
            if (cmd_next != OPCODE)  ph <= PH_REJECT;
            else if (DUMMY_CLKS == 0) ph <= PH_ARMED;
            else                      ph <= PH_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: if (rise) begin
          if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
            cnt <= '0;
            ph  <= PH_ARMED;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ARMED: if (fall) ph <= PH_DATA;
        default: ;
      endcase
    end
  end

  assign load_o  = (ph == PH_ARMED) && fall;
  assign shift_o = (ph == PH_DATA) && fall;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < CNT_MAX);

  // R6
  cmd_restart_chk: assert property (@(posedge clk) disable iff (rst)
    csn |=> (ph == PH_CMD && cnt == '0));

  // R7
  reject_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_REJECT && !csn) |=> ph == PH_REJECT);
endmodule

// File: rtl/op2_resp_store.sv
module op2_resp_store #(
  parameter int TAG_W = 96,
  parameter int CNT_W = 32,
  parameter int SIG_W = 256,
  localparam int BUF_W = TAG_W + CNT_W + SIG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [TAG_W-1:0] tag,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SIG_W-1:0] sig,
  output logic [BUF_W-1:0] resp_o
);
  logic [BUF_W-1:0] resp_q;

  always_ff @(posedge clk) begin
    if (rst)     resp_q <= '0;
    else if (ld) resp_q <= {tag, cnt, sig};
  end

  assign resp_o = resp_q;

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(resp_q));
endmodule

// File: rtl/op2_shift_out.sv
module op2_shift_out #(
  parameter int FRAME_W = 392
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csn,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame,
  output logic               miso_o
);
  logic [FRAME_W-1:0] sr_q;
  logic               miso_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      miso_q <= 1'b0;
    end else if (csn) begin
      miso_q <= 1'b0;
    end else if (load) begin
      miso_q <= frame[FRAME_W-1];
      sr_q   <= {frame[FRAME_W-2:0], 1'b0};
    end else if (shift) begin
      miso_q <= sr_q[FRAME_W-1];
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso_o = miso_q;

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    csn |=> !miso_q);

  // R2
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!csn && !load && !shift) |=> $stable(miso_q));
endmodule

// File: rtl/op2_resp_ser.sv
module op2_resp_ser #(
  parameter int   OP_W       = 8,
  parameter int   DUMMY_CLKS = 8,
  parameter logic [OP_W-1:0] OPCODE = 8'h96,
  parameter int   STAT_W     = 8,
  parameter int   TAG_W      = 96,
  parameter int   CNT_W      = 32,
  parameter int   SIG_W      = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_csn,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic [STAT_W-1:0] stat_i,
  input  logic             ld_i,
  input  logic [TAG_W-1:0] ld_tag_i,
  input  logic [CNT_W-1:0] ld_cnt_i,
  input  logic [SIG_W-1:0] ld_sig_i
);
  localparam int BUF_W   = TAG_W + CNT_W + SIG_W;
  localparam int FRAME_W = STAT_W + BUF_W;

  logic             rise, fall, load, shift;
  logic [BUF_W-1:0] resp;

  op2_sck_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sck    (spi_sck),
    .rise_o (rise),
    .fall_o (fall)
  );

  op2_phase_ctl #(
    .OP_W       (OP_W),
    .DUMMY_CLKS (DUMMY_CLKS),
    .OPCODE     (OPCODE)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .csn     (spi_csn),
    .mosi    (spi_mosi),
    .rise    (rise),
    .fall    (fall),
    .load_o  (load),
    .shift_o (shift)
  );

  op2_resp_store #(
    .TAG_W (TAG_W),
    .CNT_W (CNT_W),
    .SIG_W (SIG_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld_i),
    .tag    (ld_tag_i),
    .cnt    (ld_cnt_i),
    .sig    (ld_sig_i),
    .resp_o (resp)
  );

  op2_shift_out #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .csn    (spi_csn),
    .load   (load),
    .shift  (shift),
    .frame  ({stat_i, resp}),
    .miso_o (spi_miso)
  );
endmodule

// File: tb/sim_op2_resp_ser.sv
module sim_op2_resp_ser;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int FRAME_BITS = 392;
  localparam int PRE        = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sck = 1'b0;
  logic         csn = 1'b1;
  logic         mosi = 1'b0;
  logic         miso;
  logic [7:0]   stat = 8'h00;
  logic         ld = 1'b0;
  logic [95:0]  tag_in = '0;
  logic [31:0]  cnt_in = '0;
  logic [255:0] sig_in = '0;

  int checks = 0;
  int errors = 0;
  logic smp [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  op2_resp_ser u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .stat_i(stat), .ld_i(ld), .ld_tag_i(tag_in),
    .ld_cnt_i(cnt_in), .ld_sig_i(sig_in)
  );

  function automatic logic exp_bit(input logic [7:0] s, input logic [95:0] t,
                                   input logic [31:0] c, input logic [255:0] g,
                                   input int k);
    logic [391:0] v;
    v = {s, t, c, g};
    if (k < FRAME_BITS) return v[FRAME_BITS-1-k];
    return 1'b0;
  endfunction

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic load_buf(input logic [95:0] t, input logic [31:0] c, input logic [255:0] g);
    @(negedge clk);
    tag_in = t; cnt_in = c; sig_in = g; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] op, input int nbits);
    @(negedge clk);
    csn = 1'b0; sck = 1'b0;
    for (int i = 0; i < PRE + nbits; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'($urandom);
      wait_half();
      smp[i] = miso;
      sck = 1'b1;
      wait_half();
      sck = 1'b0;
    end
    wait_half();
    csn = 1'b1;
    wait_half();
  endtask

  task automatic chk_pre(input string req);
    int bad = -1;
    for (int i = 0; i < PRE; i++) if (smp[i] !== 1'b0 && bad < 0) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: preamble bit %0d actual %b expected 0", req, bad, smp[bad]);
    end
  endtask

  task automatic chk_frame(input string req, input logic [7:0] s, input logic [95:0] t,
                           input logic [31:0] c, input logic [255:0] g, input int nbits);
    int bad = -1;
    logic e;
    for (int k = 0; k < nbits; k++)
      if (bad < 0 && smp[PRE+k] !== exp_bit(s, t, c, g, k)) bad = k;
    checks++;
    if (bad >= 0) begin
      e = exp_bit(s, t, c, g, bad);
      errors++;
      $display("FAIL %s: frame bit %0d actual %b expected %b", req, bad, smp[PRE+bad], e);
    end
  endtask

  task automatic chk_zero(input string req, input int nbits);
    int bad = -1;
    for (int i = 0; i < PRE + nbits; i++) if (smp[i] !== 1'b0 && bad < 0) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: bit %0d actual %b expected 0", req, bad, smp[bad]);
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0]  t1, t2;
    logic [31:0]  c1, c2;
    logic [255:0] g1, g2;
    int seed_v;
    seed_v = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state
    checks++;
    if (miso !== 1'b0) begin
      errors++; $display("FAIL R1: reset miso actual %b expected 0", miso);
    end

    // R4 reset clears buffer: read with empty buffer, status 80h
    stat = 8'h80;
    xfer(8'h96, FRAME_BITS);
    chk_pre("R1");
    chk_frame("R4 reset", 8'h80, '0, '0, '0, FRAME_BITS);

    // R2/R3/R8: random loaded frame with overrun
    t1 = {$urandom, $urandom, $urandom};
    c1 = $urandom;
    g1 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    load_buf(t1, c1, g1);
    stat = 8'h80;
    xfer(8'h96, FRAME_BITS + 8);
    chk_pre("R1");
    checks++;
    if (smp[PRE] !== 1'b1) begin
      errors++; $display("FAIL R2: first data bit actual %b expected 1", smp[PRE]);
    end
    chk_frame("R3 R4", 8'h80, t1, c1, g1, FRAME_BITS);
    chk_frame("R8", 8'h80, t1, c1, g1, FRAME_BITS + 8);

    // R5: busy poll, status only
    stat = 8'h01;
    xfer(8'h96, 8);
    chk_frame("R5 busy", 8'h01, t1, c1, g1, 8);
    stat = 8'h80;
    xfer(8'h96, 8);
    chk_frame("R5 done", 8'h80, t1, c1, g1, 8);

    // R6: abort inside tag, then restart from status
    stat = 8'h80;
    xfer(8'h96, 8 + 37);
    chk_frame("R6 abort", 8'h80, t1, c1, g1, 8 + 37);
    xfer(8'h96, 8 + 96 + 20);
    chk_pre("R6");
    chk_frame("R6 restart", 8'h80, t1, c1, g1, 8 + 96 + 20);

    // R7: wrong opcodes
    xfer(8'h95, 64);
    chk_zero("R7", 64);
    xfer(8'h16, 64);
    chk_zero("R7", 64);
    xfer(8'h96, 16);
    chk_frame("R7 recover", 8'h80, t1, c1, g1, 16);

    // R9: load while shifting
    t2 = {$urandom, $urandom, $urandom};
    c2 = $urandom;
    g2 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    fork
      xfer(8'h96, FRAME_BITS);
      begin
        repeat (2 * HALF * (PRE + 40)) @(negedge clk);
        load_buf(t2, c2, g2);
      end
    join
    chk_frame("R9 old", 8'h80, t1, c1, g1, FRAME_BITS);
    xfer(8'h96, FRAME_BITS);
    chk_frame("R9 new", 8'h80, t2, c2, g2, FRAME_BITS);

    // R3/R6: random loads and abort lengths
    for (int n = 0; n < 6; n++) begin
      int len;
      t1 = {$urandom, $urandom, $urandom};
      c1 = $urandom;
      g1 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      stat = 8'($urandom);
      load_buf(t1, c1, g1);
      len = 1 + int'($urandom % 400);
      xfer(8'h96, len);
      chk_pre("R1");
      chk_frame("R3 random", stat, t1, c1, g1, len);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule